// File: doc/BRIEF.md
# Alarm Tone Generator with Debounced Trigger and Motor-Test Detect

This block turns a slow, noisy alarm contact into a single-bit speaker drive signal. The contact is an asynchronous pad modelled by two inputs: one says whether the pad is driven at all, the other gives the driven level. Both are synchronized and then qualified against a 32768 Hz clock enable that also times everything else. Once the pad has sat at the active level for a set number of ticks, the alarm turns on. The output is then a square-wave carrier, gated by a slower modulation square wave and again by a repeating on/off burst pattern. Each burst begins in its on phase.

The same pad doubles as a service input. If it is held at the level opposite to the alarm level for long enough, a motor-test request rises and stays up while that level is held. While the pad is left undriven, a low-rate test square wave is presented for probing. The active level, the carrier and modulation divisors, the burst pattern and both qualification times are elaboration parameters. Their defaults give a 2048 Hz carrier, 8 Hz modulation, 0.5 s / 0.5 s bursts, about 23.4 ms of debounce, about 32 ms for the motor-test hold, and a 128 Hz test wave.

Top module: `alarm_tone_gen`

## Requirements
- R1: The alarm (`alarm_active`) turns on only after the synchronized pad has been driven (`pad_drv`=1) with `pad_lvl` equal to `ACTIVE_LEVEL` for `DEB_TICKS` consecutive ticks. A shorter active pulse leaves the alarm off.
- R2: Leaving the active level is qualified by the same `DEB_TICKS` count. `tone_out` is 0 in the same cycle that `alarm_active` falls.
- R3: Only `pad_lvl` equal to `ACTIVE_LEVEL` counts as active. A driven pad at the opposite level never turns the alarm on.
- R4: While the alarm is on, in its on phase and in the high half of the modulation, `tone_out` is 1 for the first `CARRIER_DIV`/2 ticks of every `CARRIER_DIV` ticks and 0 for the rest.
- R5: The carrier passes only during the first `MOD_DIV`/2 ticks of every `MOD_DIV` ticks, counted from the start of the burst.
- R6: The burst repeats with an on phase first. `BURST_MODE`=0 gives `BURST_UNIT` ticks on and `BURST_UNIT` ticks off. `BURST_MODE`=1 gives 2*`BURST_UNIT` ticks on and 6*`BURST_UNIT` off. The carrier and modulation phases restart at the start of every burst. The tick on which the alarm turns on is burst position 0.
- R7: `tone_out` is 0 during reset, while the alarm is off, during an off phase and during the low half of the modulation.
- R8: When the pad is driven at the level opposite to `ACTIVE_LEVEL` for `MT_TICKS` ticks, `mtest_req` rises. It stays 1 while that level is held and drops on the first clock after the synchronized pad leaves that level. A shorter hold gives no request.
- R9: While the synchronized pad is undriven, `test_out` is a square wave that is high for the first `TEST_DIV`/2 ticks of every `TEST_DIV` ticks. The wave starts high. It is 0 while the pad is driven.
- R10: Every count advances only on clock edges where `tick_en` is 1. The alarm state and `tone_out` change only after such edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable at the 32768 Hz base rate |
| pad_drv | input | 1 | Asynchronous: the alarm pad is driven (0 = left open) |
| pad_lvl | input | 1 | Asynchronous: level on the pad when driven |
| alarm_active | output | 1 | Qualified alarm state |
| tone_out | output | 1 | Gated alarm tone |
| mtest_req | output | 1 | Motor-test request |
| test_out | output | 1 | Test square wave while the pad is open |

## Verification
A pad change reaches the logic on the second clock edge after it is applied. With a tick on every clock, `alarm_active` therefore moves on the (`DEB_TICKS`+2)-th edge after the pad changes, in both directions. `mtest_req` rises on the (`MT_TICKS`+2)-th edge and drops on the third edge after release. `test_out` restarts high on the second edge after the pad is opened. The bench drives inputs at the falling edge and samples after each rising edge. It counts edges from every pad change and compares each output at exactly those counts. `tone_out` is predicted from the number of ticks since the alarm turned on, including across a stretch of sparse ticks.

// File: rtl/alarm_tone_pkg.sv
package alarm_tone_pkg;
   // Burst pattern variants
   typedef enum logic {
      BURST_EVEN   = 1'b0,   // unit on, unit off
      BURST_SPARSE = 1'b1    // two units on, six units off
   } burst_mode_e;

   // Level qualifier variants
   typedef enum logic {
      QUAL_SYMMETRIC = 1'b0, // both edges need COUNT stable ticks
      QUAL_HOLD      = 1'b1  // assert after COUNT ticks, drop at once
   } qual_mode_e;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("alarm_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pipe <= '{default: '0};
      end else begin
         pipe[0] <= din;
         for (int i = 1; i < STAGES; i++) begin
            pipe[i] <= pipe[i-1];
         end
      end
   end

   assign dout = pipe[STAGES-1];
endmodule

// File: rtl/alarm_qualify.sv
module alarm_qualify
   import alarm_tone_pkg::*;
#(
   parameter qual_mode_e  MODE  = QUAL_SYMMETRIC,
   parameter int unsigned COUNT = 768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic level,
   output logic state
);
   localparam int unsigned CW = $clog2(COUNT + 1);

   if (COUNT < 1) begin : g_bad_count
      $error("alarm_qualify: COUNT must be at least 1");
   end

   logic [CW-1:0] cnt;

   if (MODE == QUAL_SYMMETRIC) begin : g_sym
      logic state_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt     <= '0;
            state_q <= 1'b0;
         end else if (level == state_q) begin
            cnt <= '0;
         end else if (tick) begin
            if (cnt == CW'(COUNT - 1)) begin
               state_q <= level;
               cnt     <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
      assign state = state_q;
   end else begin : g_hold
      always_ff @(posedge clk) begin
         if (!rst_n || !level) begin
            cnt <= '0;
         end else if (tick && (cnt != CW'(COUNT))) begin
            cnt <= cnt + 1'b1;
         end
      end
      assign state = (cnt == CW'(COUNT));
   end
endmodule

// File: rtl/alarm_tone.sv
module alarm_tone #(
   parameter int unsigned CARRIER_DIV = 16,
   parameter int unsigned MOD_DIV     = 4096,
   parameter int unsigned ON_TICKS    = 16384,
   parameter int unsigned OFF_TICKS   = 16384
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic enable,
   output logic tone
);
   localparam int unsigned PERIOD = ON_TICKS + OFF_TICKS;
   localparam int unsigned BW     = $clog2(PERIOD);
   localparam int unsigned CW     = $clog2(CARRIER_DIV);
   localparam int unsigned MW     = $clog2(MOD_DIV);

   logic [BW-1:0] burst_cnt;
   logic [CW-1:0] car_cnt;
   logic [MW-1:0] mod_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         burst_cnt <= '0;
         car_cnt   <= '0;
         mod_cnt   <= '0;
      end else if (tick) begin
         if (burst_cnt == BW'(PERIOD - 1)) begin
            // new burst: every phase restarts together
            burst_cnt <= '0;
            car_cnt   <= '0;
            mod_cnt   <= '0;
         end else begin
            burst_cnt <= burst_cnt + 1'b1;
            car_cnt   <= (car_cnt == CW'(CARRIER_DIV - 1)) ? '0 : car_cnt + 1'b1;
            mod_cnt   <= (mod_cnt == MW'(MOD_DIV - 1))     ? '0 : mod_cnt + 1'b1;
         end
      end
   end

   assign tone = enable
               && (burst_cnt < BW'(ON_TICKS))
               && (mod_cnt   < MW'(MOD_DIV / 2))
               && (car_cnt   < CW'(CARRIER_DIV / 2));
endmodule

// File: rtl/alarm_tone_gen.sv
module alarm_tone_gen
   import alarm_tone_pkg::*;
#(
   parameter logic        ACTIVE_LEVEL = 1'b0,
   parameter int unsigned CARRIER_DIV  = 16,
   parameter int unsigned MOD_DIV      = 4096,
   parameter burst_mode_e BURST_MODE   = BURST_EVEN,
   parameter int unsigned BURST_UNIT   = 16384,
   parameter int unsigned DEB_TICKS    = 768,
   parameter int unsigned MT_TICKS     = 1049,
   parameter int unsigned TEST_DIV     = 256,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic pad_drv,
   input  logic pad_lvl,
   output logic alarm_active,
   output logic tone_out,
   output logic mtest_req,
   output logic test_out
);
   localparam int unsigned TW = $clog2(TEST_DIV);

   if ((CARRIER_DIV < 2) || (CARRIER_DIV % 2 != 0)) begin : g_bad_car
      $error("alarm_tone_gen: CARRIER_DIV must be even and at least 2");
   end
   if ((MOD_DIV < 2) || (MOD_DIV % 2 != 0)) begin : g_bad_mod
      $error("alarm_tone_gen: MOD_DIV must be even and at least 2");
   end
   if ((TEST_DIV < 2) || (TEST_DIV % 2 != 0)) begin : g_bad_test
      $error("alarm_tone_gen: TEST_DIV must be even and at least 2");
   end
   if (BURST_UNIT < 1) begin : g_bad_unit
      $error("alarm_tone_gen: BURST_UNIT must be at least 1");
   end
   if (MT_TICKS <= DEB_TICKS) begin : g_bad_mt
      $error("alarm_tone_gen: MT_TICKS must exceed DEB_TICKS");
   end

   // pad synchronization
   logic [1:0] pad_s;
   logic       drv_s, lvl_s;

   alarm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({pad_drv, pad_lvl}),
      .dout (pad_s)
   );
   assign {drv_s, lvl_s} = pad_s;

   logic at_active, at_opposite, pad_open;
   assign at_active   = drv_s && (lvl_s == ACTIVE_LEVEL);
   assign at_opposite = drv_s && (lvl_s != ACTIVE_LEVEL);
   assign pad_open    = !drv_s;

   // alarm debounce and motor-test hold detection
   alarm_qualify #(.MODE(QUAL_SYMMETRIC), .COUNT(DEB_TICKS)) u_deb (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_en),
      .level(at_active),
      .state(alarm_active)
   );

   alarm_qualify #(.MODE(QUAL_HOLD), .COUNT(MT_TICKS)) u_mt (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_en),
      .level(at_opposite),
      .state(mtest_req)
   );

   // tone shaper, burst pattern chosen by parameter
   if (BURST_MODE == BURST_EVEN) begin : g_even
      alarm_tone #(
         .CARRIER_DIV(CARRIER_DIV), .MOD_DIV(MOD_DIV),
         .ON_TICKS(BURST_UNIT), .OFF_TICKS(BURST_UNIT)
      ) u_tone (
         .clk(clk), .rst_n(rst_n), .tick(tick_en),
         .enable(alarm_active), .tone(tone_out)
      );
   end else begin : g_sparse
      alarm_tone #(
         .CARRIER_DIV(CARRIER_DIV), .MOD_DIV(MOD_DIV),
         .ON_TICKS(2 * BURST_UNIT), .OFF_TICKS(6 * BURST_UNIT)
      ) u_tone (
         .clk(clk), .rst_n(rst_n), .tick(tick_en),
         .enable(alarm_active), .tone(tone_out)
      );
   end

   // test square wave while the pad is open
   logic [TW-1:0] test_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !pad_open) begin
         test_cnt <= '0;
      end else if (tick_en) begin
         test_cnt <= (test_cnt == TW'(TEST_DIV - 1)) ? '0 : test_cnt + 1'b1;
      end
   end

   assign test_out = pad_open && (test_cnt < TW'(TEST_DIV / 2));
endmodule

// File: rtl/alarm_tone_gen_chk.sv
module alarm_tone_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_en,
   input logic alarm_active,
   input logic tone_out,
   input logic mtest_req
);
   // R8: the two qualified states exclude each other (MT_TICKS > DEB_TICKS)
   assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mtest_req && alarm_active));

   // R10: alarm state moves only after a tick edge
   assert_alarm_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(alarm_active) |-> $past(tick_en));

   // R10: tone moves only after a tick edge
   assert_tone_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tone_out) |-> $past(tick_en));

   // R2: tone is silent in the cycle the alarm drops
   assert_silent_on_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alarm_active) |-> !tone_out);

   // R6: a burst opens with carrier high at position 0
   assert_burst_opens_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_active) |-> tone_out);
endmodule

bind alarm_tone_gen alarm_tone_gen_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_en     (tick_en),
   .alarm_active(alarm_active),
   .tone_out    (tone_out),
   .mtest_req   (mtest_req)
);

// File: tb/test_alarm_tone_gen.sv
module test_alarm_tone_gen;
   import alarm_tone_pkg::*;

   localparam int CD  = 4;
   localparam int MD  = 16;
   localparam int U   = 33;
   localparam int ON  = 2 * U;
   localparam int PER = 8 * U;
   localparam int DEB = 12;
   localparam int MT  = 20;
   localparam int TD  = 8;

   logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b1, pad_drv = 1'b0, pad_lvl = 1'b0;
   logic alarm_active, tone_out, mtest_req, test_out;

   alarm_tone_gen #(
      .ACTIVE_LEVEL(1'b0), .CARRIER_DIV(CD), .MOD_DIV(MD),
      .BURST_MODE(BURST_SPARSE), .BURST_UNIT(U),
      .DEB_TICKS(DEB), .MT_TICKS(MT), .TEST_DIV(TD)
   ) i_alarm_tone_gen (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .pad_drv(pad_drv), .pad_lvl(pad_lvl),
      .alarm_active(alarm_active), .tone_out(tone_out),
      .mtest_req(mtest_req), .test_out(test_out)
   );

   always #4 clk = ~clk;

   int n_vec = 0, n_bad = 0, k = 0;
   bit a_prev = 1'b0;

   // expected tone at k ticks after turn-on (R4 R5 R6)
   function automatic int tone_f(int b);
      int p = b % PER;
      return ((p < ON) && ((p % MD) < MD / 2) && ((p % CD) < CD / 2)) ? 1 : 0;
   endfunction

   task automatic cmp(string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", what, act, exp, $time);
      end
   endtask

   // one clock: drive tick, advance, then compare at the falling edge
   task automatic step(bit tk, bit ea, string ra, int em, int et);
      tick_en = tk;
      @(posedge clk);
      @(negedge clk);
      if (ea && !a_prev) k = 0;
      else if (a_prev && tk) k++;
      a_prev = ea;
      cmp(ra, alarm_active, ea);
      cmp("R4 R5 R6 R7 R10 tone_out", tone_out, ea ? tone_f(k) : 0);
      if (em >= 0) cmp("R8 mtest_req", mtest_req, em);
      if (et >= 0) cmp("R9 test_out", test_out, et);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog R1 run stalled: got running expected done");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      cmp("R7 reset alarm_active", alarm_active, 0);
      cmp("R7 reset tone_out", tone_out, 0);
      cmp("R8 reset mtest_req", mtest_req, 0);
      rst_n = 1'b1;
      repeat (3) step(1, 0, "R7 idle alarm_active", 0, -1);

      // R1 R2: active pulses of every length around the debounce count
      for (int L = 1; L <= DEB + 1; L++) begin
         pad_drv = 1'b1; pad_lvl = 1'b0;
         for (int n = 1; n <= L + DEB + 6; n++) begin
            if (n == L + 1) pad_drv = 1'b0;
            step(1, (L >= DEB) && (n >= DEB + 2) && (n < L + DEB + 2),
                 (n > L) ? "R2 alarm_active release" : "R1 alarm_active debounce",
                 0, -1);
         end
      end

      // R3 R4 R5 R6 R10: long alarm, two full bursts, a sparse-tick stretch
      pad_drv = 1'b1; pad_lvl = 1'b0;
      for (int n = 1; n <= DEB + 2 + 2 * PER + 40; n++) begin
         bit tk;
         tk = ((n > DEB + 2 + PER + 10) && (n <= DEB + 2 + PER + 70)) ? (n % 3 == 0) : 1'b1;
         step(tk, n >= DEB + 2, "R3 R10 alarm_active", 0, (n >= 2) ? 0 : -1);
      end
      pad_drv = 1'b0;
      for (int n = 1; n <= DEB + 4; n++)
         step(1, n < DEB + 2, "R2 alarm_active release", 0, -1);

      // R8: opposite level held one tick too short
      pad_drv = 1'b1; pad_lvl = 1'b1;
      for (int n = 1; n <= MT + 3; n++) begin
         if (n == MT) pad_drv = 1'b0;
         step(1, 0, "R3 alarm_active opposite", 0, -1);
      end

      // R8 R3 R9: opposite level held long, then opened
      pad_drv = 1'b1; pad_lvl = 1'b1;
      for (int n = 1; n <= MT + 30; n++)
         step(1, 0, "R3 alarm_active opposite", (n >= MT + 2) ? 1 : 0, (n >= 2) ? 0 : -1);
      pad_drv = 1'b0;
      for (int n = 1; n <= 3 * TD + 2; n++)
         step(1, 0, "R7 alarm_active open", (n <= 2) ? 1 : 0,
              (n == 1) ? 0 : ((((n - 2) % TD) < TD / 2) ? 1 : 0));

      finish_run();
   end
endmodule